// File: doc/BRIEF.md
# Chainable Presettable Synchronous Up Counter

This block is a synchronous binary up counter built from 4-bit stages that are chained into a wider word. Every state bit changes together on the rising clock edge. There is no ripple between bits or between stages. The counter can be cleared, or loaded with a parallel value, at any edge. It counts only when two enables are both high, so one enable can gate many counters and the other can carry the count between them.

Inside the block, each stage passes its terminal-count flag forward as the carry-enable of the next stage. The flag is combinational from the carry-enable and the stage's own value, which gives look-ahead carry across the whole chain. The top-level terminal-count output works the same way, so two instances of the block can be chained in turn.

A parameter sets an optional modulus. When the modulus is non-zero, a decoder watches the count and forces a synchronous clear on the edge after the count reaches modulus minus one. The count then runs from 0 to modulus minus one instead of over the full binary range.

Top module: `chain_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `q` becomes 0 after that edge, whatever the levels of `load_n`, `cep`, `cet` and `din`.
- R2: When `rst` is low and `load_n` is low (load is active-low) at a rising edge, `q` takes the value of `din` after that edge, whatever the levels of `cep` and `cet`.
- R3: When `rst` is low, `load_n` is high and both `cep` and `cet` are high, `q` increases by one at each rising edge, modulo 2^(4*STAGES). With the defaults, 255 is followed by 0.
- R4: When `rst` is low, `load_n` is high and either `cep` or `cet` is low, `q` keeps its value across the edge.
- R5: `tc` is high exactly when `cet` is high and every bit of `q` is 1. It follows `cet` in the same cycle, with no clock edge in between.
- R6: A carry crosses a 4-bit stage boundary on the same edge as the increment. For example, 0x0F counts to 0x10 and 0xFF counts to 0x00 in one edge.
- R7: When MODULUS is non-zero and `q` equals MODULUS-1 at a rising edge, `q` becomes 0 after that edge, whatever the levels of `load_n`, `cep` and `cet`. With MODULUS = 0, the full binary range is used.
- R8: When several controls are active at the same edge, clear wins over load, load wins over count, and count wins over hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Synchronous active-low parallel load |
| cep | input | 1 | Count enable, shared by all stages |
| cet | input | 1 | Count enable that also gates `tc` |
| din | input | 4*STAGES | Parallel load value |
| q | output | 4*STAGES | Current count |
| tc | output | 1 | Terminal count, for chaining to a further counter |

## Verification
Clear and load are each applied together with the enables and with each other, which shows whether the priority order is right. Counting runs are placed just below a stage boundary and just below the top of the range, so that a missed carry or a missed wrap shows up as a different value from a plain increment. Each enable is dropped on its own: this separates hold caused by `cep` from hold caused by `cet`, and shows that `tc` follows `cet` without waiting for a clock edge. A second instance with modulus 10 counts through several cycles and is also parked on 9 with both enables low, which shows whether the decoded clear overrides hold.

// File: rtl/cnt_pkg.sv
`timescale 1ns/1ps
package cnt_pkg;

    localparam int NIB_W = 4;

    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic [1:0] {
        OP_CLEAR,
        OP_LOAD,
        OP_COUNT,
        OP_HOLD
    } op_e;

    typedef struct packed {
        logic clr;
        logic load_n;
        logic cep;
        logic cet;
    } ctl_t;

    // Fixed priority: clear, load, count, hold
    function automatic op_e pick_op(ctl_t c);
        if (c.clr)
            return OP_CLEAR;
        else if (!c.load_n)
            return OP_LOAD;
        else if (c.cep && c.cet)
            return OP_COUNT;
        else
            return OP_HOLD;
    endfunction

    function automatic logic is_full(nib_t v);
        return &v;
    endfunction

endpackage

// File: rtl/cnt_stage.sv
`timescale 1ns/1ps
module cnt_stage
    import cnt_pkg::*;
(
    input  logic clk,
    input  ctl_t ctl,
    input  nib_t d,
    output nib_t q,
    output logic tc
);

    op_e  op;
    nib_t q_r;

    always_comb op = pick_op(ctl);

    always_ff @(posedge clk) begin
        case (op)
            OP_CLEAR: q_r <= '0;
            OP_LOAD:  q_r <= d;
            OP_COUNT: q_r <= q_r + 1'b1;
            default:  q_r <= q_r;
        endcase
    end

    assign q  = q_r;
    assign tc = ctl.cet & is_full(q_r);

    // R1
    stage_clear_chk: assert property (@(posedge clk) ctl.clr |=> (q == '0));

    // R2
    stage_load_chk: assert property (@(posedge clk) disable iff (ctl.clr)
        !ctl.load_n |=> (q == $past(d)));

    // R3
    stage_count_chk: assert property (@(posedge clk) disable iff (ctl.clr)
        (ctl.load_n && ctl.cep && ctl.cet) |=> (q == nib_t'($past(q) + 1'b1)));

    // R4
    stage_hold_chk: assert property (@(posedge clk) disable iff (ctl.clr)
        (ctl.load_n && !(ctl.cep && ctl.cet)) |=> $stable(q));

endmodule

// File: rtl/mod_decode.sv
`timescale 1ns/1ps
module mod_decode #(
    parameter int W       = 8,
    parameter int MODULUS = 0
) (
    input  logic         rst,
    input  logic [W-1:0] q,
    output logic         clr
);

    generate
        if (MODULUS == 0) begin : g_full
            logic unused_q;
            assign unused_q = ^q;
            assign clr      = rst;
        end else begin : g_mod
            localparam logic [W-1:0] TERM = W'(MODULUS - 1);
            assign clr = rst | (q == TERM);
        end
    endgenerate

endmodule

// File: rtl/chain_counter.sv
`timescale 1ns/1ps
module chain_counter
    import cnt_pkg::*;
#(
    parameter int STAGES  = 2,
    parameter int MODULUS = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_n,
    input  logic                    cep,
    input  logic                    cet,
    input  logic [STAGES*NIB_W-1:0] din,
    output logic [STAGES*NIB_W-1:0] q,
    output logic                    tc
);

    localparam int W = STAGES * NIB_W;

    logic [STAGES:0] carry;
    logic            clr;

    assign carry[0] = cet;

    mod_decode #(.W(W), .MODULUS(MODULUS)) u_dec (
        .rst (rst),
        .q   (q),
        .clr (clr)
    );

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            ctl_t ctl_i;
            assign ctl_i = '{clr: clr, load_n: load_n, cep: cep, cet: carry[i]};
            cnt_stage u_stage (
                .clk (clk),
                .ctl (ctl_i),
                .d   (din[i*NIB_W +: NIB_W]),
                .q   (q[i*NIB_W +: NIB_W]),
                .tc  (carry[i+1])
            );
        end
    endgenerate

    assign tc = carry[STAGES];

    // R5
    tc_full_chk: assert property (@(posedge clk) disable iff (rst)
        tc |-> (&q));

    // R5
    tc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !cet |-> !tc);

    // R6
    wide_inc_chk: assert property (@(posedge clk) disable iff (clr)
        (load_n && cep && cet) |=> (q == W'($past(q) + 1'b1)));

    generate
        if (MODULUS != 0) begin : g_mod_chk
            // R7
            mod_wrap_chk: assert property (@(posedge clk) disable iff (rst)
                (q == W'(MODULUS - 1)) |=> (q == '0));
        end
    endgenerate

endmodule

// File: tb/chain_counter_tb.sv
`timescale 1ns/1ps
module chain_counter_tb;

    localparam int W  = 8;
    localparam int MW = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst, load_n, cep, cet, tc;
    logic [W-1:0]  din, q;
    logic          m_rst, m_load_n, m_cep, m_cet, m_tc;
    logic [MW-1:0] m_din, m_q;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q = 0;
    int m_exp = 0;

    chain_counter #(.STAGES(2), .MODULUS(0)) u_dut (
        .clk(clk), .rst(rst), .load_n(load_n), .cep(cep), .cet(cet),
        .din(din), .q(q), .tc(tc)
    );

    chain_counter #(.STAGES(1), .MODULUS(10)) u_mod (
        .clk(clk), .rst(m_rst), .load_n(m_load_n), .cep(m_cep), .cet(m_cet),
        .din(m_din), .q(m_q), .tc(m_tc)
    );

    function automatic int model(int cur, bit r, bit l, bit p, bit t,
                                 int d, int span, int modv);
        if (r) return 0;
        if (modv != 0 && cur == modv - 1) return 0;
        if (!l) return d;
        if (p && t) return (cur + 1) % span;
        return cur;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic drive(bit r, bit l, bit p, bit t, int d, string tag);
        rst = r; load_n = l; cep = p; cet = t; din = W'(d);
        exp_q = model(exp_q, r, l, p, t, d, 256, 0);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " q"}, 32'(q), 32'(exp_q));
        chk({tag, " tc"}, 32'(tc), 32'(t && exp_q == 255));
    endtask

    task automatic mdrive(bit r, bit l, bit p, bit t, int d, string tag);
        m_rst = r; m_load_n = l; m_cep = p; m_cet = t; m_din = MW'(d);
        m_exp = model(m_exp, r, l, p, t, d, 16, 10);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " q"}, 32'(m_q), 32'(m_exp));
        chk({tag, " tc"}, 32'(m_tc), 32'(t && m_exp == 15));
    endtask

    task automatic t_reset();
        drive(1, 1, 1, 1, 0, "R1 reset state");
        drive(1, 1, 1, 1, 0, "R1 reset held");
    endtask

    task automatic t_clear_over_load();
        drive(0, 0, 0, 0, 8'h5A, "R2 load");
        drive(1, 0, 1, 1, 8'hAA, "R1 R8 clear beats load");
    endtask

    task automatic t_load_over_count();
        drive(0, 0, 1, 1, 8'h3C, "R2 R8 load beats count");
    endtask

    task automatic t_count_hold();
        for (int i = 0; i < 4; i++) drive(0, 1, 1, 1, 0, "R3 count");
        drive(0, 1, 0, 1, 0, "R4 hold cep low");
        drive(0, 1, 1, 0, 0, "R4 hold cet low");
        drive(0, 1, 0, 0, 8'hFF, "R4 hold din ignored");
    endtask

    task automatic t_carry();
        drive(0, 0, 0, 0, 8'h0E, "R2 load 0E");
        drive(0, 1, 1, 1, 0, "R6 to 0F");
        drive(0, 1, 1, 1, 0, "R6 carry to 10");
    endtask

    task automatic t_wrap();
        drive(0, 0, 0, 0, 8'hFE, "R2 load FE");
        drive(0, 1, 1, 1, 0, "R3 R5 to FF tc high");
        drive(0, 1, 1, 1, 0, "R3 R6 wrap to 00");
    endtask

    task automatic t_tc_cet_low();
        drive(0, 0, 1, 0, 8'hFF, "R5 load FF tc low");
        cet = 1'b1;
        #1;
        chk("R5 tc follows cet", 32'(tc), 32'd1);
        cet = 1'b0;
        #1;
        chk("R5 tc drops with cet", 32'(tc), 32'd0);
        drive(0, 1, 1, 0, 0, "R4 R5 hold FF cet low");
    endtask

    task automatic t_modulo();
        mdrive(1, 1, 1, 1, 0, "R7 mod reset");
        for (int i = 0; i < 23; i++) mdrive(0, 1, 1, 1, 0, "R7 mod10 count");
        mdrive(0, 0, 0, 0, 9, "R7 load 9");
        mdrive(0, 1, 0, 0, 0, "R7 decoded clear beats hold");
        mdrive(0, 0, 0, 0, 9, "R7 load 9 again");
        mdrive(0, 0, 1, 1, 5, "R7 decoded clear beats load");
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        rst = 1; load_n = 1; cep = 0; cet = 0; din = '0;
        m_rst = 1; m_load_n = 1; m_cep = 0; m_cet = 0; m_din = '0;
        @(negedge clk);
        t_reset();
        t_clear_over_load();
        t_load_over_count();
        t_count_hold();
        t_carry();
        t_wrap();
        t_tc_cet_low();
        t_modulo();
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1 to R8: got timeout expected completion");
        summary();
        $finish;
    end

endmodule